// File: doc/BRIEF.md
# Retransmit FIFO Buffer

This block is a first-in first-out store of 4096 nine-bit words. Everything runs on one clock. A dual-port array holds the data. A write pointer and a read pointer address the array independently, and each one wraps from the last address back to zero. The write and read strobes are sampled on the rising clock edge. A strobe is accepted only when its side is free: a write is accepted while the buffer is not full, and a read while it is not empty. An accepted read loads the word at the read pointer into a registered output, so it appears one cycle after the strobe. A word written into an empty buffer can be fetched by the very next read.

The main extra is a rewind input. It sends the read pointer back to address zero and reloads the occupancy with the number of words written since reset. A stream that has already been consumed can therefore be replayed, for example to send a packet again or to show a line twice. Three level flags report the occupancy: empty, full, and at least half full. The reset input is active low and asynchronous. Its release must already be synchronous to the clock.

Top module: `fifo_rt`

## Requirements
- R1: While reset is applied and just after it, empty is 1, full is 0, half_full is 0 and rd_data is 0.
- R2: Accepted reads return words in the order they were accepted for writing. The word appears on rd_data in the cycle after the read strobe is sampled.
- R3: A write strobe while full is 1 is ignored. The occupancy does not change and no stored word is overwritten.
- R4: A read strobe while empty is 1 is ignored. rd_data holds its value and the flags do not change.
- R5: When rewind is sampled high, the next accepted read returns the word at address zero, and the following reads return the words after it in order. A read strobe in the same cycle as rewind is ignored.
- R6: After rewind, the occupancy equals the number of words written since reset, counting a write accepted in the same cycle. Rewind is valid only while fewer than 4096 words have been written since reset.
- R7: A write and a read accepted in the same cycle leave the occupancy unchanged.
- R8: The flags follow the occupancy. empty is 1 exactly at 0, full is 1 exactly at 4096, and half_full is 1 at 2048 or more.
- R9: A word written into an empty buffer can be read in the next cycle, with no extra latency.
- R10: Both pointers wrap from address 4095 to 0 without corrupting data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release must be synchronous |
| wr_stb | input | 1 | Write strobe, sampled at the rising edge |
| wr_data | input | 9 | Word to store |
| rd_stb | input | 1 | Read strobe, sampled at the rising edge |
| rewind | input | 1 | Retransmit: read pointer to zero, occupancy reloaded |
| rd_data | output | 9 | Registered output word |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy is 4096 |
| half_full | output | 1 | Occupancy is 2048 or more |

## Verification
The assertions check the following on every cycle:
- A write strobe into a full buffer leaves the write pointer unchanged.
- A read strobe on an empty buffer holds rd_data and the read pointer.
- Rewind lands the read pointer on zero.
- The pointer distance always equals the occupancy count.
- A simultaneous write and read holds the count, and the count never exceeds the depth.

Only the bench scenarios can show the rest: that data replays in the right order after rewind, that a word rejected while full leaves the stored stream intact, and that data survives pointer wrap under random traffic.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  localparam int unsigned DEF_WIDTH = 9;
  localparam int unsigned DEF_DEPTH = 4096;

  typedef struct packed {
    logic empty;
    logic full;
    logic half;
  } level_flags_t;
endpackage

// File: rtl/fifo_rt_ptr.sv
module fifo_rt_ptr #(
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          rewind,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_nxt;

  // Power-of-two depth: the increment wraps on its own.
  always_comb begin
    ptr_nxt = ptr;
    if (rewind)   ptr_nxt = '0;
    else if (adv) ptr_nxt = ptr + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_nxt;
  end

  // R10: the last address is followed by address zero
  assert_ptr_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !rewind && (ptr == '1)) |=> (ptr == '0));
endmodule

// File: rtl/fifo_rt_level.sv
module fifo_rt_level
  import fifo_rt_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ok,
  input  logic          rd_ok,
  input  logic          rewind,
  input  logic [CW-1:0] reload,
  output logic [CW-1:0] count,
  output level_flags_t  flags
);
  localparam logic [CW-1:0] FULL_AT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_AT = CW'(DEPTH / 2);

  logic [CW-1:0] count_nxt;

  always_comb begin
    count_nxt = count;
    if (rewind) begin
      count_nxt = reload;
    end else begin
      unique case ({wr_ok, rd_ok})
        2'b10:   count_nxt = count + CW'(1);
        2'b01:   count_nxt = count - CW'(1);
        default: count_nxt = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_nxt;
  end

  always_comb begin
    flags.empty = (count == '0);
    flags.full  = (count == FULL_AT);
    flags.half  = (count >= HALF_AT);
  end

  // R7: a balanced write and read leave the level alone
  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && rd_ok && !rewind) |=> $stable(count));

  // R8: the level never passes the depth
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_AT);
endmodule

// File: rtl/fifo_rt_mem.sv
module fifo_rt_mem #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned AW    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  localparam int unsigned WORDS = 1 << AW;

  logic [WIDTH-1:0] store [WORDS];
  logic [WIDTH-1:0] rdata_nxt;

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_comb rdata_nxt = re ? store[raddr] : rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_nxt;
  end
endmodule

// File: rtl/fifo_rt.sv
module fifo_rt
  import fifo_rt_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH,
  parameter int unsigned DEPTH = DEF_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_stb,
  input  logic             rewind,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full,
  output logic             half_full
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] count;
  logic [CW-1:0] reload;
  level_flags_t  flags;
  logic          wr_ok;
  logic          rd_ok;

  // Guards: no write when full; no read when empty or rewinding.
  always_comb begin
    wr_ok  = wr_stb && !flags.full;
    rd_ok  = rd_stb && !flags.empty && !rewind;
    reload = {1'b0, wr_ptr} + {{AW{1'b0}}, wr_ok};
  end

  fifo_rt_ptr #(.AW(AW)) u_wr_ptr (
    .clk(clk), .rst_n(rst_n), .adv(wr_ok), .rewind(1'b0), .ptr(wr_ptr)
  );

  fifo_rt_ptr #(.AW(AW)) u_rd_ptr (
    .clk(clk), .rst_n(rst_n), .adv(rd_ok), .rewind(rewind), .ptr(rd_ptr)
  );

  fifo_rt_level #(.DEPTH(DEPTH), .CW(CW)) u_level (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .rd_ok(rd_ok),
    .rewind(rewind), .reload(reload), .count(count), .flags(flags)
  );

  fifo_rt_mem #(.WIDTH(WIDTH), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(wr_ok), .waddr(wr_ptr), .wdata(wr_data),
    .re(rd_ok), .raddr(rd_ptr), .rdata(rd_data)
  );

  always_comb begin
    empty     = flags.empty;
    full      = flags.full;
    half_full = flags.half;
  end

  // R3: a strobe into a full store moves nothing
  assert_full_blocks_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_stb) |=> $stable(wr_ptr));

  // R4: a strobe on an empty store keeps the output word
  assert_empty_holds_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_stb && !rewind) |=> ($stable(rd_data) && $stable(rd_ptr)));

  // R5: rewind lands the read side on address zero
  assert_rewind_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> (rd_ptr == '0));

  // R6: pointer distance always matches the occupancy
  assert_ptr_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr - rd_ptr) == count[AW-1:0]);

  // R8: empty and full exclude each other
  assert_flag_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full) && !(empty && half_full));
endmodule

// File: tb/fifo_rt_bench.sv
module fifo_rt_bench;
  localparam int DEPTH = 4096;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_stb, rd_stb, rewind;
  logic [8:0] wr_data;
  logic [8:0] rd_data;
  logic       empty, full, half_full;

  int checks = 0;
  int errors = 0;

  logic [8:0] m_mem [DEPTH];
  int         m_wp, m_rp, m_cnt;
  logic [8:0] m_q;

  always #2.5 clk = ~clk;

  fifo_rt u_fifo_rt (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_stb(rd_stb), .rewind(rewind), .rd_data(rd_data),
    .empty(empty), .full(full), .half_full(half_full)
  );

  function automatic logic [2:0] exp_flags(int cnt);
    return {cnt == 0, cnt == DEPTH, cnt >= DEPTH / 2};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_stb = 0; rd_stb = 0; rewind = 0; wr_data = '0;
    repeat (2) @(negedge clk);
    m_wp = 0; m_rp = 0; m_cnt = 0; m_q = '0;
    rst_n = 1'b1;
  endtask

  // One cycle: drive after the falling edge, update the model at the
  // rising edge, compare at the next falling edge.
  task automatic step(bit w, logic [8:0] d, bit r, bit rt, string tag);
    bit wok, rok;
    wr_stb = w; wr_data = d; rd_stb = r; rewind = rt;
    @(posedge clk);
    wok = w && (m_cnt != DEPTH);
    rok = r && (m_cnt != 0) && !rt;
    if (rok) begin m_q = m_mem[m_rp]; m_rp = (m_rp + 1) % DEPTH; end
    if (wok) begin m_mem[m_wp] = d; m_wp = (m_wp + 1) % DEPTH; end
    if (rt) begin m_rp = 0; m_cnt = m_wp; end
    else m_cnt = m_cnt + int'(wok) - int'(rok);
    @(negedge clk);
    wr_stb = 0; rd_stb = 0; rewind = 0;
    chk(tag, rd_data, m_q);
    chk("R8 flags", {empty, full, half_full}, exp_flags(m_cnt));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R1 reset state
    chk("R1 empty", empty, 1); chk("R1 full", full, 0);
    chk("R1 half", half_full, 0); chk("R1 data", rd_data, 0);

    // R4 read on empty ignored
    step(0, 0, 1, 0, "R4 data held");
    chk("R4 empty kept", empty, 1);

    // R9 no fall-through latency
    step(1, 9'h1A5, 0, 0, "R2");
    step(0, 0, 1, 0, "R9 next read");
    chk("R9 word", rd_data, 9'h1A5);

    // R5 and R6 replay
    do_reset();
    for (int i = 0; i < 10; i++) step(1, 9'((i * 37 + 5) & 9'h1FF), 0, 0, "R2");
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, "R2");
    step(0, 0, 1, 1, "R5 read ignored on rewind");
    chk("R5 held word", rd_data, 9'(3 * 37 + 5));
    for (int i = 0; i < 10; i++) step(0, 0, 1, 0, "R5 replay");
    chk("R6 drained after replay", empty, 1);
    step(1, 9'h0F0, 0, 1, "R6 rewind with write");
    for (int i = 0; i < 11; i++) step(0, 0, 1, 0, "R6 replay");
    chk("R6 last word", rd_data, 9'h0F0);
    chk("R6 empty", empty, 1);

    // R7, R8 levels, R3 full protection
    do_reset();
    for (int i = 0; i < 2047; i++) step(1, 9'($urandom), 0, 0, "R2");
    chk("R8 below half", half_full, 0);
    step(1, 9'h0AA, 1, 0, "R7 balanced");
    chk("R7 level kept", half_full, 0);
    step(1, 9'h055, 0, 0, "R2");
    chk("R8 at half", half_full, 1);
    for (int i = 0; i < 2048; i++) step(1, 9'($urandom), 0, 0, "R2");
    chk("R8 full", full, 1);
    step(1, 9'h155, 0, 0, "R3 write on full");
    chk("R3 still full", full, 1);
    step(1, 9'h0EE, 1, 0, "R3 read with blocked write");
    chk("R3 one slot free", full, 0);
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, "R3 contents");
    chk("R3 drained", empty, 1);

    // R10 random traffic across pointer wrap
    for (int i = 0; i < 20000; i++)
      step(($urandom % 100) < 55, 9'($urandom), ($urandom % 100) < 50, 0, "R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule